// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare

This block is a 32-bit interval timer for a system-on-chip peripheral bus. A counting step is derived from one of three externally supplied tick enables, picked by a source field and thinned out by a programmable prescaler. On every step the count falls by one. When it passes zero it either wraps to all-ones (free-run) or restarts from a programmable load value (reload). A compare register watches the running count. When they match, a sticky flag is raised, and that flag can drive an interrupt line.

Software reaches the timer through a simple word-addressed register port. It offers a control word, a status flag, the load value, the compare value and a read-only view of the live count. Writing the soft-reset bit returns the timer to a known state but keeps the enable and mode bits. With the overwrite option set, any write to the load register is copied straight into the running counter.

Top module: `pit_timer`

## Requirements
- R1: After rst_n is held low for a clock edge, control reads 0, status reads 0, load reads 32'hFFFF_FFFF, compare reads 0, count reads 32'hFFFF_FFFF and irq is low.
- R2: Register word addresses are: 0 control, 1 status, 2 load, 3 compare, 4 count. Count is read-only, and a write to it leaves the counter unchanged. Addresses 5 to 7 read as 0 and writes to them change nothing.
- R3: A control write keeps only bits 25:0. Bits 31:26 always read as 0.
- R4: Control bits 25:24 select the step source: 00 none, 01 tick_main, 10 tick_fast, 11 tick_slow. With 00 the counter never moves, and ticks on unselected inputs are ignored.
- R5: Control bits 15:4 hold a prescale value P. The counter steps once per P+1 selected ticks, counted from the moment the timer is enabled.
- R6: Control bit 0 is enable. While it is 0 the count holds. A control write that takes enable from 0 to 1 with enable-mode (bit 1) set loads the counter with the load value if reload (bit 3) is set, and with all-ones otherwise. With bit 1 clear, counting resumes from the held value.
- R7: A step taken at count 0 gives the load value in reload mode (bit 3 = 1) and all-ones in free-run mode. Any other step decrements the count by one.
- R8: With overwrite (bit 17) set, a load-register write puts the written value into the counter on the same clock edge. In reload mode that value is also used for later reloads.
- R9: Status bit 0 is set by a step whose resulting count equals the compare value, but only while enable and compare-interrupt enable (bit 2) are both 1. It stays set until it is cleared.
- R10: Writing status with bit 0 = 1 clears the flag. Writing bit 0 = 0 has no effect. A set in the same cycle as a clear wins.
- R11: irq is high exactly when the status flag, compare-interrupt enable and enable are all 1.
- R12: A control write with bit 16 set keeps bits 0, 1 and 18 to 21 of the written value and clears every other control bit, including bit 16 itself. It also sets status and compare to 0 and sets load and count to all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_main | input | 1 | Step source 01 enable |
| tick_fast | input | 1 | Step source 10 enable |
| tick_slow | input | 1 | Step source 11 enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Compare interrupt |

## Verification
The count is driven with single tick pulses on each source in turn. This separates correct source selection from ticks that leak in from unselected inputs, and separates prescale values 0 and 2 by the exact pulse on which the count moves. Runs cross zero in both modes, which separates reload from wrap-to-all-ones, and repeat with a load overwritten mid-run to show the new value reaches the live count and later reloads. Compare runs are made with the compare-interrupt enable off and then on. Flag clears are written with bit 0 at 0 and at 1, and the enable and interrupt-enable bits are toggled separately to show each one gates irq.

// File: rtl/pit_pkg.sv
// Package: shared widths, register addresses and control bit positions for
// the periodic down-counter timer. Assumes a 32-bit data path and 3-bit word address.
package pit_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 26;
    localparam int PSC_W  = 12;
    localparam int SRC_W  = 2;
    localparam int HOLD_W = 4;

    // register word addresses
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_LOAD = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CMP  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd4;

    // control bit positions
    localparam int B_EN      = 0;
    localparam int B_ENMOD   = 1;
    localparam int B_CIE     = 2;
    localparam int B_RLD     = 3;
    localparam int B_PSC_LO  = 4;
    localparam int B_SWR     = 16;
    localparam int B_OVW     = 17;
    localparam int B_HOLD_LO = 18;
    localparam int B_SRC_LO  = 24;

    typedef enum logic [SRC_W-1:0] {
        SRC_OFF  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_FAST = 2'd2,
        SRC_SLOW = 2'd3
    } step_src_e;

    // decoded control fields used outside the register file
    typedef struct packed {
        logic             en;
        logic             cmp_ie;
        logic             reload;
        logic [PSC_W-1:0] psc;
        step_src_e        src;
    } ctrl_t;
endpackage

// File: rtl/pit_tick_gen.sv
// Step generator: picks one tick enable by the source field and lets one of
// every psc+1 selected ticks through as a counter step. Source code 0 is off.
// Assumes tick inputs are single-cycle enables synchronous to clk.
module pit_tick_gen #(
    parameter int PSC_W = pit_pkg::PSC_W,
    parameter int SRC_W = pit_pkg::SRC_W,
    localparam int NSRC = 1 << SRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [PSC_W-1:0] psc,
    input  logic [NSRC-2:0]  src_ticks,
    output logic             step
);
    logic [NSRC-1:0]  gated;
    logic [PSC_W-1:0] div_q;
    logic             sel_tick;
    logic             div_done;

    // build source table: entry 0 is the "off" source
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (g == 0) begin : g_off
            assign gated[g] = 1'b0;
        end else begin : g_on
            assign gated[g] = src_ticks[g-1];
        end
    end

    // selected tick and end-of-division detect
    always_comb begin
        sel_tick = gated[src_sel];
        div_done = (div_q >= psc);
        step     = run && sel_tick && div_done;
    end

    // prescale divider count, cleared while stopped or on restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            div_q <= '0;
        end else if (sel_tick) begin
            div_q <= div_done ? '0 : div_q + 1'b1;
        end
    end

    // R4
    src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == '0) |-> !step);

    // R5
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart) |=> (div_q == '0));
endmodule

// File: rtl/pit_counter.sv
// Down counter with wrap/reload and compare-match detection. A load request
// overrides a step in the same cycle; a match is only reported for a real step.
module pit_counter #(
    parameter int DATA_W = pit_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              reload,
    input  logic              cmp_arm,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] cnt,
    output logic              hit
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [DATA_W-1:0] nxt;

    // next count after one step, and compare detect on it
    always_comb begin
        if (cnt == '0) begin
            nxt = reload ? load_val : ALL_ONES;
        end else begin
            nxt = cnt - 1'b1;
        end
        hit = step && !ld && cmp_arm && (nxt == cmp_val);
    end

    // counter register: load request first, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ALL_ONES;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (step) begin
            cnt <= nxt;
        end
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld) |=> $stable(cnt));

    // R8
    load_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && cnt == '0 && !reload) |=> (cnt == ALL_ONES));

    // R7
    dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pit_regfile.sv
// Register file: control, status flag, load and compare registers, read mux,
// soft reset and the counter load requests raised by control and load writes.
// Assumes a single-cycle write strobe; reads are combinational from addr.
module pit_regfile
    import pit_pkg::*;
#(
    parameter int DATA_W = pit_pkg::DATA_W,
    parameter int ADDR_W = pit_pkg::ADDR_W,
    parameter int CTRL_W = pit_pkg::CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    input  logic [DATA_W-1:0] cnt,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic              cnt_ld,
    output logic [DATA_W-1:0] cnt_ld_val,
    output logic              div_restart,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] ALL_ONES  = '1;
    localparam logic [CTRL_W-1:0] HOLD_MASK = CTRL_W'(((1 << HOLD_W) - 1) << B_HOLD_LO);
    localparam logic [CTRL_W-1:0] KEEP_MASK = HOLD_MASK
                                            | CTRL_W'(1 << B_EN)
                                            | CTRL_W'(1 << B_ENMOD);

    logic [CTRL_W-1:0] ctrl_q;
    logic              status_q;
    logic [CTRL_W-1:0] wval;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic              swr, en_rise;

    // write decode and soft-reset / enable-edge detect
    always_comb begin
        wval    = wdata[CTRL_W-1:0];
        wr_ctrl = wr_en && (addr == ADR_CTRL);
        wr_stat = wr_en && (addr == ADR_STAT);
        wr_load = wr_en && (addr == ADR_LOAD);
        wr_cmp  = wr_en && (addr == ADR_CMP);
        swr     = wr_ctrl && wval[B_SWR];
        en_rise = wr_ctrl && !swr && wval[B_EN] && !ctrl_q[B_EN];
    end

    // counter load request: soft reset, then enable edge, then overwrite
    always_comb begin
        cnt_ld     = 1'b0;
        cnt_ld_val = ALL_ONES;
        if (swr) begin
            cnt_ld = 1'b1;
        end else if (en_rise && wval[B_ENMOD]) begin
            cnt_ld     = 1'b1;
            cnt_ld_val = wval[B_RLD] ? load_q : ALL_ONES;
        end else if (wr_load && ctrl_q[B_OVW]) begin
            cnt_ld     = 1'b1;
            cnt_ld_val = wdata;
        end
        div_restart = swr || en_rise;
    end

    // control register, soft reset keeps only the enable/mode/hold bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= swr ? (wval & KEEP_MASK) : wval;
        end
    end

    // load and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n || swr) begin
            load_q <= ALL_ONES;
            cmp_q  <= '0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_cmp)  cmp_q  <= wdata;
        end
    end

    // sticky compare flag: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n || swr) begin
            status_q <= 1'b0;
        end else if (hit) begin
            status_q <= 1'b1;
        end else if (wr_stat && wdata[0]) begin
            status_q <= 1'b0;
        end
    end

    // decoded fields and interrupt
    always_comb begin
        ctrl.en     = ctrl_q[B_EN];
        ctrl.cmp_ie = ctrl_q[B_CIE];
        ctrl.reload = ctrl_q[B_RLD];
        ctrl.psc    = ctrl_q[B_PSC_LO +: PSC_W];
        ctrl.src    = step_src_e'(ctrl_q[B_SRC_LO +: SRC_W]);
        irq         = status_q && ctrl_q[B_CIE] && ctrl_q[B_EN];
    end

    // read mux
    always_comb begin
        case (addr)
            ADR_CTRL: rdata = DATA_W'(ctrl_q);
            ADR_STAT: rdata = DATA_W'(status_q);
            ADR_LOAD: rdata = load_q;
            ADR_CMP:  rdata = cmp_q;
            ADR_CNT:  rdata = cnt;
            default:  rdata = '0;
        endcase
    end

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !swr) |=> status_q);

    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[0] && !hit) |=> !status_q);

    // R12
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (load_q == ALL_ONES && cmp_q == '0 && !status_q && !ctrl_q[B_SWR]));
endmodule

// File: rtl/pit_timer.sv
// Top of the periodic down-counter timer: ties the register file, the step
// generator and the counter together. Tick inputs are clk-synchronous enables.
module pit_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_main,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] load_q, cmp_q, cnt, cnt_ld_val;
    logic              cnt_ld, div_restart, step, hit;

    pit_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .hit         (hit),
        .cnt         (cnt),
        .ctrl        (ctrl),
        .load_q      (load_q),
        .cmp_q       (cmp_q),
        .cnt_ld      (cnt_ld),
        .cnt_ld_val  (cnt_ld_val),
        .div_restart (div_restart),
        .rdata       (rdata),
        .irq         (irq)
    );

    pit_tick_gen #(.PSC_W(PSC_W), .SRC_W(SRC_W)) u_ticks (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl.en),
        .restart   (div_restart),
        .src_sel   (ctrl.src),
        .psc       (ctrl.psc),
        .src_ticks ({tick_slow, tick_fast, tick_main}),
        .step      (step)
    );

    pit_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .reload   (ctrl.reload),
        .cmp_arm  (ctrl.en && ctrl.cmp_ie),
        .ld       (cnt_ld),
        .ld_val   (cnt_ld_val),
        .load_val (load_q),
        .cmp_val  (cmp_q),
        .cnt      (cnt),
        .hit      (hit)
    );
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_main = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_LOAD = 3'd2, A_CMP = 3'd3, A_CNT = 3'd4;

    pit_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_main(tick_main), .tick_fast(tick_fast),
        .tick_slow(tick_slow), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    // mask bit0 main, bit1 fast, bit2 slow
    task automatic pulse(input logic [2:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {tick_slow, tick_fast, tick_main} = m;
            @(negedge clk);
            {tick_slow, tick_fast, tick_main} = 3'b000;
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", A_CTRL, 32'h0);
        rd_chk("R1 status", A_STAT, 32'h0);
        rd_chk("R1 load", A_LOAD, 32'hFFFF_FFFF);
        rd_chk("R1 cmp", A_CMP, 32'h0);
        rd_chk("R1 count", A_CNT, 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ctrl_mask;
        wr(A_CTRL, 32'hFC3C_0000);
        rd_chk("R3 upper bits dropped", A_CTRL, 32'h003C_0000);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_modes;
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'h0100_000B);
        rd_chk("R6 enable-mode loads load value", A_CNT, 32'd5);
        pulse(3'b001, 2);
        rd_chk("R7 decrement", A_CNT, 32'd3);
        pulse(3'b001, 3);
        rd_chk("R7 reach zero", A_CNT, 32'd0);
        pulse(3'b001, 1);
        rd_chk("R7 reload from load", A_CNT, 32'd5);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0100_0003);
        rd_chk("R6 enable-mode free-run all-ones", A_CNT, 32'hFFFF_FFFF);
        pulse(3'b001, 1);
        rd_chk("R7 free-run decrement", A_CNT, 32'hFFFF_FFFE);
        wr(A_CTRL, 32'h0102_0003);
        wr(A_LOAD, 32'd2);
        rd_chk("R8 overwrite into count", A_CNT, 32'd2);
        pulse(3'b001, 3);
        rd_chk("R7 free-run wrap to all-ones", A_CNT, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0102_000B);
        wr(A_LOAD, 32'd4);
        rd_chk("R8 overwrite in reload mode", A_CNT, 32'd4);
        pulse(3'b001, 5);
        rd_chk("R8 new value used on reload", A_CNT, 32'd4);
    endtask

    task automatic t_prescale;
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd100);
        wr(A_CTRL, 32'h0100_002B);
        pulse(3'b001, 2);
        rd_chk("R5 no step before third tick", A_CNT, 32'd100);
        pulse(3'b001, 1);
        rd_chk("R5 step on third tick", A_CNT, 32'd99);
        pulse(3'b001, 3);
        rd_chk("R5 second divided step", A_CNT, 32'd98);
    endtask

    task automatic t_sources;
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0200_000B);
        pulse(3'b101, 2);
        rd_chk("R4 unselected ticks ignored", A_CNT, 32'd100);
        pulse(3'b010, 2);
        rd_chk("R4 fast source counts", A_CNT, 32'd98);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0300_000B);
        pulse(3'b001, 1);
        pulse(3'b100, 1);
        rd_chk("R4 slow source counts", A_CNT, 32'd99);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0000_000B);
        pulse(3'b111, 2);
        rd_chk("R4 source off never moves", A_CNT, 32'd100);
    endtask

    task automatic t_resume;
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0100_000B);
        pulse(3'b001, 3);
        rd_chk("R6 running", A_CNT, 32'd97);
        wr(A_CTRL, 32'h0100_000A);
        pulse(3'b001, 2);
        rd_chk("R6 disabled holds", A_CNT, 32'd97);
        wr(A_CTRL, 32'h0100_0009);
        rd_chk("R6 resume keeps value", A_CNT, 32'd97);
        pulse(3'b001, 1);
        rd_chk("R6 resumed counting", A_CNT, 32'd96);
    endtask

    task automatic t_compare;
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd10);
        wr(A_CMP, 32'd7);
        wr(A_CTRL, 32'h0100_000B);
        pulse(3'b001, 3);
        rd_chk("R9 no flag with compare disabled", A_STAT, 32'h0);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0100_000F);
        pulse(3'b001, 2);
        rd_chk("R9 not yet matched", A_STAT, 32'h0);
        chk("R11 irq low before match", {31'b0, irq}, 32'h0);
        pulse(3'b001, 1);
        rd_chk("R9 flag on match", A_STAT, 32'h1);
        chk("R11 irq on match", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h0);
        rd_chk("R10 write 0 no effect", A_STAT, 32'h1);
        wr(A_STAT, 32'h1);
        rd_chk("R10 write 1 clears", A_STAT, 32'h0);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);
        pulse(3'b001, 10);
        rd_chk("R9 no flag before next match", A_STAT, 32'h0);
        pulse(3'b001, 1);
        rd_chk("R9 flag after reload pass", A_STAT, 32'h1);
        wr(A_CTRL, 32'h0100_000B);
        chk("R11 irq gated by compare enable", {31'b0, irq}, 32'h0);
        rd_chk("R11 flag kept while gated", A_STAT, 32'h1);
        wr(A_CTRL, 32'h0100_000F);
        chk("R11 irq back", {31'b0, irq}, 32'h1);
        rd_chk("R6 no reload without enable edge", A_CNT, 32'd7);
        wr(A_CTRL, 32'h0100_000E);
        chk("R11 irq gated by enable", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_soft_reset;
        wr(A_CTRL, 32'h0100_000F);
        wr(A_CTRL, 32'h0105_003F);
        rd_chk("R12 control kept bits", A_CTRL, 32'h0004_0003);
        rd_chk("R12 status cleared", A_STAT, 32'h0);
        rd_chk("R12 load all-ones", A_LOAD, 32'hFFFF_FFFF);
        rd_chk("R12 compare cleared", A_CMP, 32'h0);
        rd_chk("R12 count all-ones", A_CNT, 32'hFFFF_FFFF);
    endtask

    task automatic t_map;
        wr(A_CNT, 32'h0000_1234);
        rd_chk("R2 count write ignored", A_CNT, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0000_00AA);
        rd_chk("R2 unmapped read zero", 3'd6, 32'h0);
        rd_chk("R2 unmapped write harmless", A_LOAD, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_mask();
        t_modes();
        t_prescale();
        t_sources();
        t_resume();
        t_compare();
        t_soft_reset();
        t_map();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule